// File: doc/BRIEF.md
# Calendar Alarm Match Unit

This block holds three alarm words and compares each one with the current calendar time, which a separate time-of-year counter supplies. A comparison happens only on the once-per-second strobe. A stored alarm that equals the time at that strobe sets a sticky per-slot status bit. The status bits are ORed into a single level interrupt, and software clears each bit by writing a one to it.

The calendar is live only while both its run enable and the oscillator enable are high. While it is not live, writes to the alarm words are dropped and no alarm can fire. When the calendar is live again, all three stored alarms take part in the comparison once more, without being rewritten. Software reaches the alarms and the status word through a 32-bit word port. Writes are registered. Reads are combinational from the address.

Top module: `cal_alarm_unit`

## Requirements
- R1: An alarm word holds the seconds in bits 5:0, the minutes in 11:6, the hour in 16:12, the day in 21:17, the month in 25:22 and the year in 31:26. The year field is compared only with the low six bits of the calendar year, and every field must be equal for a match.
- R2: Alarm slots 0, 1 and 2 sit at byte addresses 0x34, 0x38 and 0x3C. Each one reads back the last value it accepted. Any address that is not mapped reads as zero.
- R3: A write to an alarm slot is dropped when either the calendar run enable or the oscillator enable is low.
- R4: A slot's status bit is set at the clock edge that samples the second strobe high, but only when the calendar is live and the slot equals the current time. An equal time without the strobe sets nothing.
- R5: While the calendar is not live, no status bit is set. When the calendar is live again, the stored alarm values fire at their next matching strobe without being rewritten.
- R6: The interrupt is high whenever any status bit is set. It stays high until software clears every set bit.
- R7: The status word is at address 0x44, with bit i for slot i. Writing a one clears that bit and writing a zero leaves it unchanged. If a set and a clear reach the same bit in the same cycle, the set wins.
- R8: Reset clears all three alarm slots, all status bits and the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cal_run | input | 1 | Calendar run enable |
| osc_en | input | 1 | Oscillator enable |
| sec_tick | input | 1 | One-cycle strobe at each second boundary |
| cur_year | input | 6 | Low six bits of calendar year |
| cur_mon | input | 4 | Calendar month |
| cur_day | input | 5 | Calendar day |
| cur_hour | input | 5 | Calendar hour |
| cur_min | input | 6 | Calendar minute |
| cur_sec | input | 6 | Calendar second |
| wr_en | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte address for read and write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for bus_addr |
| irq | output | 1 | Level alarm interrupt |

## Verification
Four behaviours are checked by the assertions on every cycle:
- the interrupt never rises unless a live second strobe came just before it;
- the interrupt never falls without a write to the status address;
- a write of all ones to the status word drops the interrupt when no strobe arrives with it;
- a dropped or accepted alarm write appears correctly at the read port.

Some behaviour can be shown only by the bench's scenarios:
- whether a match needs every field to be equal;
- that the year is truncated to six bits;
- that a set wins over a simultaneous clear;
- that alarms fire again after the calendar is re-enabled;
- the reset values.

// File: rtl/cal_alarm_unit.sv
module cal_alarm_unit #(
  parameter int NSLOT = 3,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] SLOT_BASE = 8'h34,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h44
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cal_run,
  input  logic              osc_en,
  input  logic              sec_tick,
  input  logic [5:0]        cur_year,
  input  logic [3:0]        cur_mon,
  input  logic [4:0]        cur_day,
  input  logic [4:0]        cur_hour,
  input  logic [5:0]        cur_min,
  input  logic [5:0]        cur_sec,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  output logic              irq
);

  logic [31:0]      slot_q [NSLOT];
  logic [NSLOT-1:0] hit_q;

  wire        cal_on  = cal_run & osc_en;
  wire        stat_wr = wr_en && (bus_addr == STAT_ADDR);
  wire [31:0] now_w   = {cur_year, cur_mon, cur_day, cur_hour, cur_min, cur_sec};

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    localparam logic [ADDR_W-1:0] SLOT_ADDR = ADDR_W'(SLOT_BASE + ADDR_W'(4 * i));
    wire slot_wr = wr_en && (bus_addr == SLOT_ADDR) && cal_on;
    wire fire    = sec_tick && cal_on && (slot_q[i] == now_w);

    always_ff @(posedge clk) begin
      if (!rst_n)       slot_q[i] <= '0;
      else if (slot_wr) slot_q[i] <= wr_data;
    end

    always_ff @(posedge clk) begin
      if (!rst_n)                      hit_q[i] <= 1'b0;
      else if (fire)                   hit_q[i] <= 1'b1;
      else if (stat_wr && wr_data[i])  hit_q[i] <= 1'b0;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NSLOT; i++)
      if (bus_addr == ADDR_W'(SLOT_BASE + ADDR_W'(4 * i))) rd_data = slot_q[i];
    if (bus_addr == STAT_ADDR) rd_data = 32'(hit_q);
  end

  assign irq = |hit_q;

endmodule

// File: rtl/cal_alarm_unit_chk.sv
module cal_alarm_unit_chk #(
  parameter int NSLOT = 3,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] SLOT_BASE = 8'h34,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h44
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cal_run,
  input logic              osc_en,
  input logic              sec_tick,
  input logic              wr_en,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       wr_data,
  input logic [31:0]       rd_data,
  input logic              irq
);

  // R4
  irq_rise_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(sec_tick && cal_run && osc_en));

  // R6
  irq_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(wr_en && bus_addr == STAT_ADDR)) |=> irq);

  // R7
  clear_all_drops_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && bus_addr == STAT_ADDR && (&wr_data[NSLOT-1:0]) && !sec_tick) |=> !irq);

  // R2
  slot_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && bus_addr == SLOT_BASE && cal_run && osc_en)
      |=> (bus_addr != SLOT_BASE || rd_data == $past(wr_data)));

  // R3
  slot_write_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && bus_addr == SLOT_BASE && !(cal_run && osc_en))
      |=> (bus_addr != SLOT_BASE || rd_data == $past(rd_data)));

endmodule

bind cal_alarm_unit cal_alarm_unit_chk #(
  .NSLOT(NSLOT), .ADDR_W(ADDR_W), .SLOT_BASE(SLOT_BASE), .STAT_ADDR(STAT_ADDR)
) u_chk (.*);

// File: tb/test_cal_alarm_unit.sv
`timescale 1ns/1ps
module test_cal_alarm_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cal_run = 1'b0, osc_en = 1'b0, sec_tick = 1'b0;
  logic [5:0]  cur_year = '0, cur_min = '0, cur_sec = '0;
  logic [3:0]  cur_mon = '0;
  logic [4:0]  cur_day = '0, cur_hour = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        irq;
  int nchk = 0, nfail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cal_alarm_unit i_cal_alarm_unit (.*);

  function automatic logic [31:0] pack(input int y, mo, d, h, mi, s);
    return {6'(y), 4'(mo), 5'(d), 5'(h), 6'(mi), 6'(s)};
  endfunction

  task automatic check(input string req, input logic [31:0] act, exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; bus_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1 d = rd_data;
  endtask

  task automatic set_time(input int y, mo, d, h, mi, s);
    @(negedge clk);
    cur_year = 6'(y); cur_mon = 4'(mo); cur_day = 5'(d);
    cur_hour = 5'(h); cur_min = 6'(mi); cur_sec = 6'(s);
  endtask

  task automatic tick();
    @(negedge clk); sec_tick = 1;
    @(negedge clk); sec_tick = 0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int i = 0; i < 3; i++) begin
      rd(8'(8'h34 + 4 * i), v); check("R8 slot after reset", v, 0);
    end
    rd(8'h44, v); check("R8 status after reset", v, 0);
    check("R8 irq after reset", {31'b0, irq}, 0);
  endtask

  task automatic t_readback();
    logic [31:0] v;
    cal_run = 1; osc_en = 1;
    wr(8'h34, pack(5, 7, 14, 9, 30, 16));
    wr(8'h38, pack(5, 7, 14, 9, 30, 15));
    wr(8'h3C, pack(6, 7, 14, 9, 30, 15));
    rd(8'h34, v); check("R2 slot0", v, pack(5, 7, 14, 9, 30, 16));
    rd(8'h38, v); check("R2 slot1", v, pack(5, 7, 14, 9, 30, 15));
    rd(8'h3C, v); check("R2 slot2", v, pack(6, 7, 14, 9, 30, 15));
    rd(8'h40, v); check("R2 unmapped", v, 0);
  endtask

  task automatic t_ignore();
    logic [31:0] v;
    cal_run = 0;
    wr(8'h34, 32'hDEAD_BEEF);
    rd(8'h34, v); check("R3 run low", v, pack(5, 7, 14, 9, 30, 16));
    cal_run = 1; osc_en = 0;
    wr(8'h38, 32'h1234_5678);
    rd(8'h38, v); check("R3 osc low", v, pack(5, 7, 14, 9, 30, 15));
    osc_en = 1;
  endtask

  task automatic t_fire();
    logic [31:0] v;
    set_time(5, 7, 14, 9, 30, 15);
    repeat (3) @(negedge clk);
    rd(8'h44, v); check("R4 no strobe no hit", v, 0);
    tick();
    rd(8'h44, v); check("R4 slot1 hit", v, 3'b010);
    check("R6 irq high", {31'b0, irq}, 1);
    repeat (4) @(negedge clk);
    rd(8'h44, v); check("R6 sticky", v, 3'b010);
    set_time(5, 7, 14, 9, 30, 16);
    tick();
    rd(8'h44, v); check("R1 slot0 hit", v, 3'b011);
  endtask

  task automatic t_clear();
    logic [31:0] v;
    wr(8'h44, 0);
    rd(8'h44, v); check("R7 zero write no effect", v, 3'b011);
    wr(8'h44, 1);
    rd(8'h44, v); check("R7 clear bit0", v, 3'b010);
    check("R6 irq still high", {31'b0, irq}, 1);
    wr(8'h44, 2);
    rd(8'h44, v); check("R7 clear bit1", v, 0);
    check("R6 irq low", {31'b0, irq}, 0);
  endtask

  task automatic t_set_wins();
    logic [31:0] v;
    set_time(5, 7, 14, 9, 30, 15);
    @(negedge clk); sec_tick = 1; wr_en = 1; bus_addr = 8'h44; wr_data = 2;
    @(negedge clk); sec_tick = 0; wr_en = 0;
    rd(8'h44, v); check("R7 set beats clear", v, 3'b010);
    wr(8'h44, 7);
  endtask

  task automatic t_year();
    logic [31:0] v;
    set_time(6, 7, 14, 9, 30, 15);
    tick();
    rd(8'h44, v); check("R1 year field", v, 3'b100);
    wr(8'h44, 7);
    set_time(5, 7, 14, 9, 31, 15);
    tick();
    rd(8'h44, v); check("R1 one field differs", v, 0);
  endtask

  task automatic t_disable();
    logic [31:0] v;
    set_time(5, 7, 14, 9, 30, 15);
    cal_run = 0;
    tick();
    rd(8'h44, v); check("R5 no hit while off", v, 0);
    check("R5 irq low while off", {31'b0, irq}, 0);
    cal_run = 1; osc_en = 0;
    tick();
    rd(8'h44, v); check("R5 no hit osc off", v, 0);
    osc_en = 1;
    tick();
    rd(8'h44, v); check("R5 rearmed", v, 3'b010);
  endtask

  task automatic t_reset_again();
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    t_reset();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_readback();
    t_ignore();
    t_fire();
    t_clear();
    t_set_wins();
    t_year();
    t_disable();
    t_reset_again();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule